// File: doc/BRIEF.md
# One-Wire Byte Transfer Engine

This block moves whole bytes over a single open-drain one-wire line. Software writes a byte into the data register. The engine then runs eight bit time slots on the line, least significant bit first. A 1 bit gives a short low pulse, which also acts as a read slot. A 0 bit gives a long low pulse. The line level is sampled at a fixed point in every slot, and the eight samples are built into a receive byte. To read a byte from a device, software sends 0xFF, so that every slot is a read slot, and then reads the assembled byte back from the same register.

The engine holds one byte in a transmit buffer and one byte in a receive buffer. A second byte can therefore be queued while a transfer is running. A received byte also waits in the shift register while the previous byte has not yet been read. Four status flags report the state of the transmit buffer, the shift register and the receive buffer. An enable register picks which flags drive the interrupt output. Slot timing is set in clock cycles by parameters. The line input passes through a synchronizer before it is sampled.

Top module: `ow_byte_engine`

## Requirements
- R1: After reset the status register (offset 0xA) reads 0x000C, with transmit-empty (bit 2) and shift-empty (bit 3) set. The enable register (offset 0xC) reads 0, the interrupt is low and the line is released.
- R2: A write to the data register (offset 0x8) while transmit-empty is set sends the low byte as eight slots, least significant bit first. A 1 bit holds the line low for W1_LOW cycles and a 0 bit for W0_LOW cycles. The line is driven only inside a slot.
- R3: The line level sampled in each slot is assembled least significant bit first. Each received bit is the AND of the sent bit and the device's bit, so sending 0xFF reads the device's byte. The byte is read from offset 0x8 in bits 7:0.
- R4: Transmit-empty (bit 2) clears on an accepted data write and sets again when the byte moves into the shift register. A data write while it is clear is ignored.
- R5: Shift-empty (bit 3) clears on an accepted data write. It sets when the last slot of a transfer ends with no byte waiting in the transmit buffer.
- R6: Receive-full (bit 4) sets when a received byte lands in the receive buffer. A read of offset 0x8 clears it.
- R7: A byte that completes while receive-full is set stays in the shift register with shift-full (bit 5) set, and no new transfer starts. A data read in that state returns the older byte and moves the held byte into the buffer in the same cycle. After that read receive-full stays set and shift-full clears.
- R8: The enable register (offset 0xC) stores bits 5:2 and reads 0 in all other bits. The interrupt is high exactly when a status flag and its matching enable bit are both set.
- R9: Offset 0x6 and all undefined offsets read 0 and ignore writes. Writes to the status register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; only a data-register read has a side effect |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the same cycle as the address |
| ow_pull_low | output | 1 | 1 pulls the open-drain line low |
| ow_line | input | 1 | Level of the line |
| irq | output | 1 | Interrupt request |

## Verification
Two events can fall on the same clock edge: a software read that clears receive-full, and the move of a held byte from the shift register into the receive buffer. The bench provokes this by leaving one received byte unread and then completing a second byte, so that shift-full is set. It queues a third byte, checks that the line stays idle, and then reads. The collision is judged correct when that read returns the first byte, receive-full stays set while shift-full clears, the next read returns the second byte, and the queued third byte then goes out on the line.

// File: rtl/ow_byte_pkg.sv
package ow_byte_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFF_CMD  = 4'h6;
  localparam logic [ADDR_W-1:0] OFF_DATA = 4'h8;
  localparam logic [ADDR_W-1:0] OFF_STAT = 4'hA;
  localparam logic [ADDR_W-1:0] OFF_IEN  = 4'hC;

  localparam int BIT_TBE  = 2;
  localparam int BIT_RSRF = 5;

  typedef struct packed {
    logic rsrf;   // bit 5
    logic rbf;    // bit 4
    logic tsre;   // bit 3
    logic tbe;    // bit 2
  } flags_t;

  function automatic logic [REG_W-1:0] place_flags(flags_t f);
    logic [REG_W-1:0] w;
    w = '0;
    w[BIT_RSRF:BIT_TBE] = f;
    return w;
  endfunction

  function automatic flags_t take_flags(logic [REG_W-1:0] w);
    return flags_t'(w[BIT_RSRF:BIT_TBE]);
  endfunction

  function automatic logic irq_any(flags_t s, flags_t e);
    return |(s & e);
  endfunction
endpackage

// File: rtl/ow_sync.sv
module ow_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES == 0) begin : g_pass
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], d} ;
      end
      assign q = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/ow_slot_timer.sv
module ow_slot_timer #(
  parameter int SLOT_CYC  = 64,
  parameter int W1_LOW    = 6,
  parameter int W0_LOW    = 48,
  parameter int SAMPLE_AT = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic bit_val,
  input  logic line_in,
  output logic busy,
  output logic drive_low,
  output logic sample_strobe,
  output logic sample_val,
  output logic slot_done
);
  localparam int CW = $clog2(SLOT_CYC);
  localparam logic [CW-1:0] LAST = CW'(SLOT_CYC - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic          bit_q;
  logic          samp_q;
  logic [CW-1:0] low_len;

  assign low_len       = bit_q ? CW'(W1_LOW) : CW'(W0_LOW);
  assign busy          = busy_q;
  assign drive_low     = busy_q && (cnt_q < low_len);
  assign sample_strobe = busy_q && (cnt_q == CW'(SAMPLE_AT));
  assign slot_done     = busy_q && (cnt_q == LAST);
  assign sample_val    = samp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      bit_q  <= 1'b1;
      samp_q <= 1'b1;
    end else begin
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
          bit_q  <= bit_val;
        end
      end else if (slot_done) begin
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (sample_strobe) samp_q <= line_in;
    end
  end
endmodule

// File: rtl/ow_byte_shifter.sv
module ow_byte_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [BITS-1:0] load_byte,
  input  logic            slot_busy,
  input  logic            slot_done,
  input  logic            sample_val,
  output logic            slot_start,
  output logic            slot_bit,
  output logic            active,
  output logic            byte_done,
  output logic [BITS-1:0] rx_byte
);
  localparam int IW = (BITS > 1) ? $clog2(BITS) : 1;

  logic            active_q;
  logic [IW-1:0]   idx_q;
  logic [BITS-1:0] tx_q;
  logic [BITS-1:0] rx_q;
  logic            done_q;

  assign active     = active_q;
  assign slot_start = active_q && !slot_busy;
  assign slot_bit   = tx_q[0];
  assign byte_done  = done_q;
  assign rx_byte    = rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load && !active_q) begin
        active_q <= 1'b1;
        idx_q    <= '0;
        tx_q     <= load_byte;
      end else if (active_q && slot_done) begin
        tx_q  <= tx_q >> 1;
        rx_q  <= {sample_val, rx_q[BITS-1:1]};
        idx_q <= idx_q + 1'b1;
        if (idx_q == IW'(BITS - 1)) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ow_byte_regs.sv
module ow_byte_regs
  import ow_byte_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              byte_done,
  input  logic [BITS-1:0]   rx_byte,
  input  logic              shift_active,
  output logic              load,
  output logic [BITS-1:0]   load_byte,
  output logic              move,
  output flags_t            flags,
  output flags_t            ien,
  output logic              irq
);
  logic [BITS-1:0] tx_buf_q;
  logic [BITS-1:0] rx_buf_q;
  flags_t          flags_q;
  flags_t          ien_q;
  logic            wr_data;
  logic            rd_data;
  logic            accept;

  assign wr_data   = bus_wr && (bus_addr == OFF_DATA);
  assign rd_data   = bus_rd && (bus_addr == OFF_DATA);
  assign accept    = wr_data && flags_q.tbe;
  assign load      = !flags_q.tbe && !shift_active && !flags_q.rsrf && !byte_done;
  assign load_byte = tx_buf_q;
  assign move      = flags_q.rsrf && (!flags_q.rbf || rd_data);
  assign flags     = flags_q;
  assign ien       = ien_q;
  assign irq       = irq_any(flags_q, ien_q);

  always_comb begin
    unique case (bus_addr)
      OFF_DATA: bus_rdata = {{(REG_W-BITS){1'b0}}, rx_buf_q};
      OFF_STAT: bus_rdata = place_flags(flags_q);
      OFF_IEN:  bus_rdata = place_flags(ien_q);
      default:  bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf_q <= '0;
      rx_buf_q <= '0;
      flags_q  <= '{rsrf: 1'b0, rbf: 1'b0, tsre: 1'b1, tbe: 1'b1};
      ien_q    <= '0;
    end else begin
      if (accept) begin
        tx_buf_q     <= bus_wdata[BITS-1:0];
        flags_q.tbe  <= 1'b0;
        flags_q.tsre <= 1'b0;
      end else begin
        if (load)                     flags_q.tbe  <= 1'b1;
        if (byte_done && flags_q.tbe) flags_q.tsre <= 1'b1;
      end

      if (byte_done)  flags_q.rsrf <= 1'b1;
      else if (move)  flags_q.rsrf <= 1'b0;

      if (move) begin
        rx_buf_q    <= rx_byte;
        flags_q.rbf <= 1'b1;
      end else if (rd_data) begin
        flags_q.rbf <= 1'b0;
      end

      if (bus_wr && (bus_addr == OFF_IEN)) ien_q <= take_flags(bus_wdata);
    end
  end
endmodule

// File: rtl/ow_byte_engine.sv
module ow_byte_engine
  import ow_byte_pkg::*;
#(
  parameter int BITS        = 8,
  parameter int SLOT_CYC    = 64,
  parameter int W1_LOW      = 6,
  parameter int W0_LOW      = 48,
  parameter int SAMPLE_AT   = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        ow_pull_low,
  input  logic        ow_line,
  output logic        irq
);
  logic            line_sync;
  logic            slot_start;
  logic            slot_bit;
  logic            slot_busy;
  logic            slot_done;
  logic            sample_strobe;
  logic            sample_val;
  logic            shift_active;
  logic            byte_done;
  logic [BITS-1:0] rx_byte;
  logic            load;
  logic [BITS-1:0] load_byte;
  logic            move;
  flags_t          flags;
  flags_t          ien;

  ow_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ow_line), .q(line_sync)
  );

  ow_slot_timer #(
    .SLOT_CYC(SLOT_CYC), .W1_LOW(W1_LOW), .W0_LOW(W0_LOW), .SAMPLE_AT(SAMPLE_AT)
  ) u_slot (
    .clk(clk), .rst_n(rst_n), .start(slot_start), .bit_val(slot_bit),
    .line_in(line_sync), .busy(slot_busy), .drive_low(ow_pull_low),
    .sample_strobe(sample_strobe), .sample_val(sample_val), .slot_done(slot_done)
  );

  ow_byte_shifter #(.BITS(BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_byte(load_byte),
    .slot_busy(slot_busy), .slot_done(slot_done), .sample_val(sample_val),
    .slot_start(slot_start), .slot_bit(slot_bit), .active(shift_active),
    .byte_done(byte_done), .rx_byte(rx_byte)
  );

  ow_byte_regs #(.BITS(BITS)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .byte_done(byte_done), .rx_byte(rx_byte), .shift_active(shift_active),
    .load(load), .load_byte(load_byte), .move(move), .flags(flags),
    .ien(ien), .irq(irq)
  );
endmodule

// File: rtl/ow_byte_engine_chk.sv
module ow_byte_engine_chk
  import ow_byte_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  bus_addr,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [15:0] bus_rdata,
  input logic        ow_pull_low,
  input logic        slot_busy,
  input logic        shift_active,
  input logic        load,
  input logic        irq,
  input flags_t      flags
);
  // R2
  pull_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ow_pull_low |-> slot_busy);

  // R2
  start_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shift_active) |-> $past(load));

  // R4
  tbe_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags.tbe) |-> $past(bus_wr && bus_addr == OFF_DATA));

  // R5
  tsre_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags.tsre |-> !shift_active);

  // R6
  rbf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags.rbf) |-> $past(bus_rd && bus_addr == OFF_DATA));

  // R7
  rsrf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags.rsrf |-> !shift_active);

  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != '0));

  // R9
  cmd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFF_CMD) |-> (bus_rdata == '0));
endmodule

bind ow_byte_engine ow_byte_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_rdata(bus_rdata), .ow_pull_low(ow_pull_low),
  .slot_busy(slot_busy), .shift_active(shift_active), .load(load),
  .irq(irq), .flags(flags)
);

// File: tb/ow_byte_engine_tb.sv
`timescale 1ns/1ps
module ow_byte_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W1_LOW     = 6;
  localparam int W0_LOW     = 48;
  localparam int SAMPLE_AT  = 14;
  localparam int RESP_HOLD  = 24;
  localparam logic [3:0] A_CMD = 4'h6, A_DATA = 4'h8, A_STAT = 4'hA, A_IEN = 4'hC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        ow_pull_low;
  logic        ow_line;
  logic        irq;
  logic        slave_low = 1'b0;

  int checks = 0;
  int errors = 0;

  // device model state
  logic [7:0] resp_byte = 8'hFF;
  int         slot_cnt = 0;
  int         hold_left = 0;
  int         low_cnt = 0;
  logic       prev_pull = 1'b0;
  logic [7:0] tx_cap = '0;
  int         w1_width = 0;
  int         w0_width = 0;

  assign ow_line = !(ow_pull_low || slave_low);

  always #(CLK_PERIOD/2) clk = ~clk;

  ow_byte_engine u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ow_pull_low(ow_pull_low), .ow_line(ow_line), .irq(irq)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_left > 0) hold_left = hold_left - 1;
      if (ow_pull_low && !prev_pull) begin
        low_cnt = 1;
        if (!resp_byte[slot_cnt % 8]) hold_left = RESP_HOLD;
        slot_cnt = slot_cnt + 1;
      end else if (ow_pull_low) begin
        low_cnt = low_cnt + 1;
      end else if (prev_pull) begin
        tx_cap = {(low_cnt < SAMPLE_AT), tx_cap[7:1]};
        if (low_cnt < SAMPLE_AT) w1_width = low_cnt;
        else                     w0_width = low_cnt;
      end
      slave_low = (hold_left > 0);
      prev_pull = ow_pull_low;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [15:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic wait_flag(input string req, input logic [15:0] mask);
    logic [15:0] v;
    bit hit = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      peek(A_STAT, v);
      if ((v & mask) != 0) begin hit = 1; break; end
    end
    if (!hit) chk(req, 16'h0, mask);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    @(negedge clk);
    peek(A_STAT, v); chk("R1 status", v, 16'h000C);
    peek(A_IEN, v);  chk("R1 enable", v, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'h0);
    chk("R1 line", {15'd0, ow_pull_low}, 16'h0);
  endtask

  task automatic t_reserved;
    logic [15:0] v;
    reg_wr(A_CMD, 16'hFFFF);
    peek(A_CMD, v); chk("R9 cmd", v, 16'h0000);
    reg_wr(A_STAT, 16'h0000);
    peek(A_STAT, v); chk("R9 status write", v, 16'h000C);
    peek(4'h0, v); chk("R9 undefined", v, 16'h0000);
  endtask

  task automatic t_write_pattern;
    logic [15:0] v;
    resp_byte = 8'hFF; slot_cnt = 0;
    reg_wr(A_DATA, 16'h00A5);
    peek(A_STAT, v); chk("R4 R5 cleared", v, 16'h0000);
    @(negedge clk);
    peek(A_STAT, v); chk("R4 tbe back", v, 16'h0004);
    wait_flag("R5 tsre", 16'h0008);
    chk("R2 lsb first", {8'd0, tx_cap}, 16'h00A5);
    chk("R2 one width", 16'(w1_width), 16'(W1_LOW));
    chk("R2 zero width", 16'(w0_width), 16'(W0_LOW));
    chk("R2 slots", 16'(slot_cnt), 16'd8);
    wait_flag("R6 rbf", 16'h0010);
    reg_rd(A_DATA, v); chk("R3 echo", v, 16'h00A5);
    peek(A_STAT, v); chk("R6 rbf cleared", v & 16'h0010, 16'h0000);
  endtask

  task automatic t_read_byte(input logic [7:0] tx, input logic [7:0] resp);
    logic [15:0] v;
    resp_byte = resp; slot_cnt = 0;
    reg_wr(A_DATA, {8'd0, tx});
    wait_flag("R6 rbf", 16'h0010);
    reg_rd(A_DATA, v); chk("R3 received", v, {8'd0, tx & resp});
  endtask

  task automatic t_collision;
    logic [15:0] v;
    int seen;
    resp_byte = 8'hFF; slot_cnt = 0;
    reg_wr(A_DATA, 16'h0081);
    repeat (3) @(negedge clk);
    reg_wr(A_DATA, 16'h0042);
    peek(A_STAT, v); chk("R4 queued", v & 16'h0004, 16'h0000);
    reg_wr(A_DATA, 16'h0099);
    wait_flag("R5 tsre", 16'h0008);
    repeat (2) @(negedge clk);
    peek(A_STAT, v); chk("R7 both full", v, 16'h003C);
    chk("R4 ignored write", {8'd0, tx_cap}, 16'h0042);
    reg_wr(A_DATA, 16'h0055);
    seen = slot_cnt;
    repeat (100) @(negedge clk);
    chk("R7 no start", 16'(slot_cnt), 16'(seen));
    peek(A_STAT, v); chk("R7 held", v, 16'h0030);
    reg_rd(A_DATA, v); chk("R7 older byte", v, 16'h0081);
    peek(A_STAT, v); chk("R7 moved", v & 16'h0030, 16'h0010);
    reg_rd(A_DATA, v); chk("R7 newer byte", v, 16'h0042);
    wait_flag("R7 resumed", 16'h0010);
    chk("R7 queued sent", {8'd0, tx_cap}, 16'h0055);
    reg_rd(A_DATA, v); chk("R7 queued byte", v, 16'h0055);
  endtask

  task automatic t_irq;
    logic [15:0] v;
    reg_wr(A_IEN, 16'hFFFF);
    peek(A_IEN, v); chk("R8 enable bits", v, 16'h003C);
    chk("R8 irq empty flags", {15'd0, irq}, 16'h1);
    reg_wr(A_IEN, 16'h0010);
    chk("R8 irq masked", {15'd0, irq}, 16'h0);
    resp_byte = 8'hFF; slot_cnt = 0;
    reg_wr(A_DATA, 16'h00FF);
    wait_flag("R8 rbf", 16'h0010);
    chk("R8 irq rbf", {15'd0, irq}, 16'h1);
    reg_rd(A_DATA, v);
    chk("R8 irq cleared", {15'd0, irq}, 16'h0);
    reg_wr(A_IEN, 16'h0008);
    chk("R8 irq tsre", {15'd0, irq}, 16'h1);
    reg_wr(A_IEN, 16'h0000);
    chk("R8 irq off", {15'd0, irq}, 16'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_reserved();
    t_write_pattern();
    t_read_byte(8'hFF, 8'h3C);
    t_read_byte(8'h0F, 8'hAA);
    t_collision();
    t_irq();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule